// File: doc/BRIEF.md
# Local Interrupt Timer

This block is the countdown timer that sits inside a per-core interrupt controller. Software sets it up through a small register write port. It writes a 32-bit vector-table entry that selects how expiry is reported. It writes an initial count that arms the timer. While the timer is armed, each asserted tick input lowers the current count by one. The current count is always visible on an output.

When the count runs out, the block looks at the entry. If the entry is not masked, the block raises a one-cycle interrupt request that carries three fields from the entry: the vector, the delivery mode and the trigger mode. In periodic mode the counter is refilled from the initial count and keeps running, whether or not the entry is masked. In one-shot mode the counter stops at zero and waits for a new initial count. Arbitration of the request and any clock prescaling happen outside this block.

Top module: `lvt_timer`

## Requirements
- R1: After reset the current count is 0 and no request is raised. The entry reads as all zeros, so a later arm with no entry write expires once as an unmasked, one-shot, edge request with vector 0 and delivery mode 0.
- R2: A write with `wr_sel`=1 loads the initial count from the low `CNT_W` bits of `wr_data` into both the reload value and the current count. A nonzero value arms the timer and zero disarms it with the count at 0. This load takes priority over a tick in the same cycle.
- R3: While armed, the count drops by one on each cycle with `tick` high and holds on cycles with `tick` low. While disarmed, ticks leave the count unchanged.
- R4: Expiry is a tick while armed with a count of 1. In the following cycle `irq_valid` is high for that cycle only. It carries the vector from entry bits 7:0 and the delivery mode from entry bits 10:8. `irq_level` comes from entry bit 15, where 1 means level and 0 means edge.
- R5: With entry bit 16 (mask) set, an expiry raises no request, and the count behaves exactly as it does when unmasked.
- R6: With entry bit 17 (periodic) set, the expiry cycle reloads the count with the initial count and the timer stays armed. This holds even when masked, so an initial count N gives one expiry every N ticks.
- R7: With bit 17 clear, the count stays at 0 after expiry and no further request is raised until a new initial count is written.
- R8: Entry bits 11 through 14 and 18 through 31 have no effect on the request fields or on counting.
- R9: A write with `wr_sel`=0 replaces the entry. From the next cycle on it governs expiries, including those of a count already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 entry, 1 initial count |
| wr_data | input | 32 | Write data |
| tick | input | 1 | Count enable, one decrement per high cycle |
| cur_count | output | CNT_W | Current count readback |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request |
| irq_mode | output | 3 | Delivery mode of the request |
| irq_level | output | 1 | Trigger mode of the request, 1 for level |

## Verification
The bench builds the timer with `CNT_W`=8. This puts the widest count, 255, within a single run of ticks. It also makes the dropping of write data above the counter width visible: a write of 0x103 must arm a count of 3. The table runs masked and unmasked entries in both modes against initial counts of 1 (periodic expiry on every tick), small values and the maximum. Directed cases cover a write colliding with a tick, disarming by a zero write, and masking an entry while a count is in flight.

// File: rtl/lvt_timer_pkg.sv
package lvt_timer_pkg;

    localparam int VEC_W  = 8;
    localparam int MODE_W = 3;
    localparam int DATA_W = 32;

    // Entry bit positions
    localparam int VEC_LSB   = 0;
    localparam int MODE_LSB  = 8;
    localparam int LEVEL_BIT = 15;
    localparam int MASK_BIT  = 16;
    localparam int PER_BIT   = 17;

    typedef enum logic {
        WSEL_ENTRY = 1'b0,
        WSEL_INIT  = 1'b1
    } wsel_e;

    // Decoded entry fields that drive behaviour
    typedef struct packed {
        logic              periodic;
        logic              mask;
        logic              level;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vector;
    } entry_cfg_t;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        logic [MODE_W-1:0] mode;
        logic              level;
    } irq_req_t;

    function automatic entry_cfg_t decode_entry(input logic [DATA_W-1:0] w);
        entry_cfg_t c;
        c.vector   = w[VEC_LSB +: VEC_W];
        c.mode     = w[MODE_LSB +: MODE_W];
        c.level    = w[LEVEL_BIT];
        c.mask     = w[MASK_BIT];
        c.periodic = w[PER_BIT];
        return c;
    endfunction

endpackage

// File: rtl/lvt_entry_reg.sv
module lvt_entry_reg
    import lvt_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output entry_cfg_t        cfg
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (wr)
            cfg <= decode_entry(wdata);
    end
endmodule

// File: rtl/lvt_down_counter.sv
module lvt_down_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] init_q,
    output logic             running,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = running && tick && (count == ONE) && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            init_q  <= '0;
            running <= 1'b0;
        end else if (load) begin
            init_q  <= load_val;
            count   <= load_val;
            running <= (load_val != '0);
        end else if (expire) begin
            if (periodic) begin
                count <= init_q;
            end else begin
                count   <= '0;
                running <= 1'b0;
            end
        end else if (running && tick) begin
            count <= count - ONE;
        end
    end
endmodule

// File: rtl/lvt_irq_gen.sv
module lvt_irq_gen
    import lvt_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       expire,
    input  entry_cfg_t cfg,
    output logic       valid,
    output irq_req_t   req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            req   <= '0;
        end else begin
            valid <= expire && !cfg.mask;
            if (expire) begin
                req.vector <= cfg.vector;
                req.mode   <= cfg.mode;
                req.level  <= cfg.level;
            end
        end
    end
endmodule

// File: rtl/lvt_timer.sv
module lvt_timer
    import lvt_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic                        wr_sel,
    input  logic [31:0]                 wr_data,
    input  logic                        tick,
    output logic [CNT_W-1:0]            cur_count,
    output logic                        irq_valid,
    output logic [7:0]                  irq_vector,
    output logic [2:0]                  irq_mode,
    output logic                        irq_level
);
    entry_cfg_t       cfg;
    irq_req_t         req;
    logic             wr_entry;
    logic             wr_init;
    logic             cnt_running;
    logic             cnt_expire;
    logic [CNT_W-1:0] cnt_init;

    assign wr_entry = wr_en && (wsel_e'(wr_sel) == WSEL_ENTRY);
    assign wr_init  = wr_en && (wsel_e'(wr_sel) == WSEL_INIT);

    lvt_entry_reg u_entry (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_entry),
        .wdata (wr_data),
        .cfg   (cfg)
    );

    lvt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_init),
        .load_val (wr_data[CNT_W-1:0]),
        .tick     (tick),
        .periodic (cfg.periodic),
        .count    (cur_count),
        .init_q   (cnt_init),
        .running  (cnt_running),
        .expire   (cnt_expire)
    );

    lvt_irq_gen u_irq (
        .clk    (clk),
        .rst    (rst),
        .expire (cnt_expire),
        .cfg    (cfg),
        .valid  (irq_valid),
        .req    (req)
    );

    assign irq_vector = req.vector;
    assign irq_mode   = req.mode;
    assign irq_level  = req.level;
endmodule

// File: rtl/lvt_timer_chk.sv
module lvt_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_init,
    input logic             tick,
    input logic [CNT_W-1:0] cur_count,
    input logic [CNT_W-1:0] cnt_init,
    input logic             cnt_running,
    input logic             mask,
    input logic             periodic,
    input logic             irq_valid
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R3: armed tick above one decrements
    a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
        (cnt_running && tick && cur_count > ONE && !wr_init)
        |=> cur_count == $past(cur_count) - ONE);

    // R3: disarmed timer holds its count
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!cnt_running && !wr_init) |=> $stable(cur_count));

    // R4: a request only follows an unmasked expiry
    a_r4_irq_source: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> $past(cnt_running && tick && cur_count == ONE && !wr_init && !mask));

    // R5: masked expiry stays silent
    a_r5_masked_silent: assert property (@(posedge clk) disable iff (rst)
        mask |=> !irq_valid);

    // R6: periodic expiry reloads and stays armed
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        (cnt_running && tick && cur_count == ONE && !wr_init && periodic)
        |=> (cur_count == $past(cnt_init)) && cnt_running);

    // R7: one-shot expiry stops at zero
    a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
        (cnt_running && tick && cur_count == ONE && !wr_init && !periodic)
        |=> (cur_count == '0) && !cnt_running);
endmodule

bind lvt_timer lvt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_init     (wr_init),
    .tick        (tick),
    .cur_count   (cur_count),
    .cnt_init    (cnt_init),
    .cnt_running (cnt_running),
    .mask        (cfg.mask),
    .periodic    (cfg.periodic),
    .irq_valid   (irq_valid)
);

// File: tb/lvt_timer_tb.sv
module lvt_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int NVEC       = 8;

    // entry, initial count write, ticks, expected requests, expected final count
    typedef struct packed {
        logic [31:0] entry;
        logic [31:0] init;
        logic [15:0] ticks;
        logic [15:0] exp_irqs;
        logic [7:0]  exp_cnt;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0031, 32'd5,     16'd7,   16'd1, 8'd0},  // R4 R7 one-shot
        '{32'h0002_8542, 32'd3,     16'd10,  16'd3, 8'd2},  // R6 periodic level
        '{32'h0003_0277, 32'd4,     16'd9,   16'd0, 8'd3},  // R5 R6 masked periodic
        '{32'h0001_0010, 32'd2,     16'd5,   16'd0, 8'd0},  // R5 masked one-shot
        '{32'hFFFC_7B99, 32'd1,     16'd1,   16'd1, 8'd0},  // R8 ignored bits
        '{32'h0002_0405, 32'd1,     16'd4,   16'd4, 8'd1},  // R6 init one
        '{32'h0000_80FF, 32'd255,   16'd255, 16'd1, 8'd0},  // R2 max count
        '{32'h0000_0020, 32'h103,   16'd3,   16'd1, 8'd0}   // R2 truncated write
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_en, wr_sel, tick;
    logic [31:0]      wr_data;
    logic [CNT_W-1:0] cur_count;
    logic             irq_valid, irq_level;
    logic [7:0]       irq_vector;
    logic [2:0]       irq_mode;

    int n_checks = 0;
    int n_fail   = 0;
    int irq_seen;
    logic [7:0] last_vec;
    logic [2:0] last_mode;
    logic       last_lvl;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvt_timer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tick(tick), .cur_count(cur_count), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_mode(irq_mode), .irq_level(irq_level)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sample_irq();
        if (irq_valid) begin
            irq_seen++;
            last_vec  = irq_vector;
            last_mode = irq_mode;
            last_lvl  = irq_level;
        end
    endtask

    // n cycles with the given tick level, requests counted
    task automatic run(input int n, input logic t);
        irq_seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample_irq();
            tick = t;
        end
        @(negedge clk);
        sample_irq();
        tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cur_count == 0, "R1 reset count", cur_count, 0);
        check(!irq_valid, "R1 reset irq", irq_valid, 0);

        // R3: disarmed ticks do nothing
        run(4, 1'b1);
        check(cur_count == 0 && irq_seen == 0, "R3 idle ticks", irq_seen, 0);

        // R1: zero entry gives unmasked one-shot edge request, vector 0
        wr(1'b1, 32'd2);
        run(5, 1'b1);
        check(irq_seen == 1, "R1 reset entry irq count", irq_seen, 1);
        check(last_vec == 0 && last_mode == 0 && !last_lvl, "R1 reset entry fields",
              {last_vec, last_mode, last_lvl}, 0);
        check(cur_count == 0, "R1 one-shot count", cur_count, 0);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            wr(1'b0, VECS[v].entry);
            wr(1'b1, VECS[v].init);
            run(int'(VECS[v].ticks), 1'b1);
            check(irq_seen == int'(VECS[v].exp_irqs), $sformatf("R4 R5 R6 vec%0d irqs", v),
                  irq_seen, int'(VECS[v].exp_irqs));
            check(cur_count == VECS[v].exp_cnt, $sformatf("R3 R6 R7 R9 vec%0d count", v),
                  cur_count, int'(VECS[v].exp_cnt));
            if (VECS[v].exp_irqs != 0) begin
                check(last_vec == VECS[v].entry[7:0], $sformatf("R4 R8 vec%0d vector", v),
                      last_vec, int'(VECS[v].entry[7:0]));
                check(last_mode == VECS[v].entry[10:8], $sformatf("R4 R8 vec%0d mode", v),
                      last_mode, int'(VECS[v].entry[10:8]));
                check(last_lvl == VECS[v].entry[15], $sformatf("R4 vec%0d level", v),
                      last_lvl, int'(VECS[v].entry[15]));
            end
        end

        // R7: one-shot stays at zero after more ticks
        wr(1'b0, 32'h0000_0044);
        wr(1'b1, 32'd2);
        run(2, 1'b1);
        run(6, 1'b1);
        check(irq_seen == 0 && cur_count == 0, "R7 no second expiry", irq_seen, 0);

        // R3: no tick, count holds
        wr(1'b1, 32'd6);
        run(5, 1'b0);
        check(cur_count == 6, "R3 hold without tick", cur_count, 6);

        // R2: zero write disarms
        wr(1'b0, 32'h0002_0011);
        run(2, 1'b1);
        check(cur_count == 4, "R3 partial count", cur_count, 4);
        wr(1'b1, 32'd0);
        check(cur_count == 0, "R2 zero write clears", cur_count, 0);
        run(8, 1'b1);
        check(irq_seen == 0 && cur_count == 0, "R2 zero write disarms", irq_seen, 0);

        // R2: load wins over simultaneous tick
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'd9; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        check(cur_count == 9, "R2 load over tick", cur_count, 9);

        // R9: masking mid-run suppresses the pending expiry
        wr(1'b0, 32'h0000_0010);
        wr(1'b1, 32'd3);
        run(1, 1'b1);
        wr(1'b0, 32'h0001_0010);
        run(3, 1'b1);
        check(irq_seen == 0, "R9 mask mid-run", irq_seen, 0);
        check(cur_count == 0, "R9 count after masked expiry", cur_count, 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule